// File: doc/BRIEF.md
# Commit Squash Sequence Resolver

This block sits beside the commit stage of an out-of-order core and keeps one commit status per hardware thread. Each cycle, and for each thread on its own, it can receive three kinds of squash request: a trap raised at commit, a squash of the whole thread context, and a squash reported by the execute stage. It picks one winner, puts the thread into the squashing state, and holds it there until the reorder buffer reports that the squash has drained. While a thread is squashing it is not allowed to commit.

When the execute stage wins, the block works out two sequence-number bounds. The first is the squash bound. The second is the delay-slot boundary, which depends on whether the squash came from a branch misprediction, on the branch's taken direction, and on whether it is a conditional branch with a delay slot. It also decides whether the delay-slot instruction is squashed. The mispredict and taken flags and two program counters are passed on to the execute stage, and a per-thread counter records mispredictions. All results are registered and appear on the clock edge that follows the request.

Top module: `squash_resolver`

## Requirements
- R1: Priority within a thread is trap, then context squash, then execute squash. One cycle after a request, `squash_src` for that thread shows the winner: 1 for trap, 2 for context, 3 for execute.
- R2: When a trap and a context squash arrive for the same thread in the same cycle, `conflict_err` for that thread is high for exactly the next cycle. The trap still wins.
- R3: Any winning squash moves the thread's status (`status`, 3 bits per thread) to 2, the squashing code, on the next edge. `squashing` is high for as long as the status is 2.
- R4: For an execute squash with mispredict, taken and conditional-delay-slot all set, the delay-slot boundary equals the squashed sequence number and `ds_squash` is 1.
- R5: For an execute squash that is a mispredict and not both taken and conditional-delay-slot, the delay-slot boundary is the squashed sequence number plus one and `ds_squash` is 0.
- R6: For an execute squash that is not a mispredict, both the squash bound and the delay-slot boundary equal the squashed sequence number and `ds_squash` is 1.
- R7: When the include flag is set, both the squash bound and the delay-slot boundary are one less than they would be otherwise. All sequence arithmetic wraps modulo 2^SEQW.
- R8: A squashing thread stays in status 2 and keeps `commit_en` low until `rob_done` is seen for it with no new squash in the same cycle. It then returns to status 0 (running). `rob_done` has no effect on a running thread.
- R9: After an execute win, the mispredict flag, taken flag, next PC and mispredicted PC are forwarded. The thread's mispredict counter increments exactly when a winning execute squash carries the mispredict flag. A trap or context win forwards a mispredict flag of 0.
- R10: Threads are independent: a request on one thread leaves every output of another thread unchanged.
- R11: After reset every thread is in status 0 with `commit_en` high, and every pulse, flag and counter output is zero.
- R12: `squash_valid` is a one-cycle pulse per winning request. The bound outputs hold their values until the next execute win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_sq | input | NTHREADS | Trap squash request per thread |
| ctx_sq | input | NTHREADS | Thread-context squash request per thread |
| exe_sq | input | NTHREADS | Execute-stage squash request per thread |
| exe_mispred | input | NTHREADS | Execute squash is a branch misprediction |
| exe_taken | input | NTHREADS | Mispredicted branch was taken |
| exe_cond_ds | input | NTHREADS | Branch is a conditional delay-slot branch |
| exe_incl | input | NTHREADS | Include the squashing instruction in the squash |
| exe_seq | input | NTHREADS*SEQW | Squashed sequence number per thread |
| exe_npc | input | NTHREADS*PCW | Redirect PC per thread |
| exe_mpc | input | NTHREADS*PCW | Mispredicted PC per thread |
| rob_done | input | NTHREADS | Reorder buffer finished squashing the thread |
| squash_valid | output | NTHREADS | One-cycle pulse for a winning request |
| squash_src | output | NTHREADS*2 | Winner: 1 trap, 2 context, 3 execute |
| conflict_err | output | NTHREADS | Trap and context squash collided |
| squash_bound | output | NTHREADS*SEQW | Squash sequence bound |
| ds_bound | output | NTHREADS*SEQW | Delay-slot boundary |
| ds_squash | output | NTHREADS | Delay-slot instruction is squashed |
| fwd_mispred | output | NTHREADS | Forwarded mispredict flag |
| fwd_taken | output | NTHREADS | Forwarded taken flag |
| fwd_npc | output | NTHREADS*PCW | Forwarded redirect PC |
| fwd_mpc | output | NTHREADS*PCW | Forwarded mispredicted PC |
| status | output | NTHREADS*3 | Commit status: 0 running, 1 idle, 2 squashing, 3 trap pending, 4 fetch trap pending |
| squashing | output | NTHREADS | Squash in progress, broadcast to other stages |
| commit_en | output | NTHREADS | Thread may commit |
| mispred_cnt | output | NTHREADS*CNTW | Per-thread misprediction counter |

## Verification
The bench uses the default parameters: two threads and 32-bit sequence numbers. Two threads are enough to show that a request on one thread leaves the other untouched. The full 32-bit width lets the bench check the wrap at both ends: decrementing from zero and incrementing from the all-ones value. The vector table covers every combination of mispredict, taken, delay-slot and include that leads to a different boundary. Directed cases then cover priority, collisions, and a squash that arrives in the same cycle as a drain.

// File: rtl/squash_resolver.sv
module squash_resolver #(
  parameter int NTHREADS = 2,
  parameter int SEQW     = 32,
  parameter int PCW      = 32,
  parameter int CNTW     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NTHREADS-1:0]      trap_sq,
  input  logic [NTHREADS-1:0]      ctx_sq,
  input  logic [NTHREADS-1:0]      exe_sq,
  input  logic [NTHREADS-1:0]      exe_mispred,
  input  logic [NTHREADS-1:0]      exe_taken,
  input  logic [NTHREADS-1:0]      exe_cond_ds,
  input  logic [NTHREADS-1:0]      exe_incl,
  input  logic [NTHREADS*SEQW-1:0] exe_seq,
  input  logic [NTHREADS*PCW-1:0]  exe_npc,
  input  logic [NTHREADS*PCW-1:0]  exe_mpc,
  input  logic [NTHREADS-1:0]      rob_done,
  output logic [NTHREADS-1:0]      squash_valid,
  output logic [NTHREADS*2-1:0]    squash_src,
  output logic [NTHREADS-1:0]      conflict_err,
  output logic [NTHREADS*SEQW-1:0] squash_bound,
  output logic [NTHREADS*SEQW-1:0] ds_bound,
  output logic [NTHREADS-1:0]      ds_squash,
  output logic [NTHREADS-1:0]      fwd_mispred,
  output logic [NTHREADS-1:0]      fwd_taken,
  output logic [NTHREADS*PCW-1:0]  fwd_npc,
  output logic [NTHREADS*PCW-1:0]  fwd_mpc,
  output logic [NTHREADS*3-1:0]    status,
  output logic [NTHREADS-1:0]      squashing,
  output logic [NTHREADS-1:0]      commit_en,
  output logic [NTHREADS*CNTW-1:0] mispred_cnt
);
  typedef enum logic [2:0] {RUNNING, IDLE, ROB_SQ, TRAP_PEND, FTRAP_PEND} cstat_t;

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
    cstat_t            st;
    logic              win_trap, win_ctx, win_exe, any_sq, kill_ds;
    logic [SEQW-1:0]   seq, dec, ds_raw;
    logic [SEQW-1:0]   bound_q, ds_q;
    logic [PCW-1:0]    npc_q, mpc_q;
    logic [CNTW-1:0]   cnt_q;
    logic [1:0]        src_q;

    assign win_trap = trap_sq[t];
    assign win_ctx  = ctx_sq[t] & ~trap_sq[t];
    assign win_exe  = exe_sq[t] & ~trap_sq[t] & ~ctx_sq[t];
    assign any_sq   = trap_sq[t] | ctx_sq[t] | exe_sq[t];
    assign seq      = exe_seq[t*SEQW +: SEQW];
    assign dec      = {{(SEQW-1){1'b0}}, exe_incl[t]};
    assign kill_ds  = ~exe_mispred[t] | (exe_taken[t] & exe_cond_ds[t]);
    assign ds_raw   = kill_ds ? seq : seq + {{(SEQW-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st              <= RUNNING;
        squash_valid[t] <= 1'b0;
        conflict_err[t] <= 1'b0;
        src_q           <= 2'd0;
        bound_q         <= '0;
        ds_q            <= '0;
        ds_squash[t]    <= 1'b0;
        fwd_mispred[t]  <= 1'b0;
        fwd_taken[t]    <= 1'b0;
        npc_q           <= '0;
        mpc_q           <= '0;
        cnt_q           <= '0;
      end else begin
        squash_valid[t] <= any_sq;
        conflict_err[t] <= trap_sq[t] & ctx_sq[t];
        if (any_sq) begin
          st    <= ROB_SQ;
          src_q <= win_trap ? 2'd1 : (win_ctx ? 2'd2 : 2'd3);
          fwd_mispred[t] <= win_exe & exe_mispred[t];
        end else if (st == ROB_SQ && rob_done[t]) begin
          st <= RUNNING;
        end
        if (win_exe) begin
          bound_q      <= seq - dec;
          ds_q         <= ds_raw - dec;
          ds_squash[t] <= kill_ds;
          fwd_taken[t] <= exe_taken[t];
          npc_q        <= exe_npc[t*PCW +: PCW];
          mpc_q        <= exe_mpc[t*PCW +: PCW];
          if (exe_mispred[t]) cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign squash_src[t*2 +: 2]        = src_q;
    assign squash_bound[t*SEQW +: SEQW] = bound_q;
    assign ds_bound[t*SEQW +: SEQW]     = ds_q;
    assign fwd_npc[t*PCW +: PCW]        = npc_q;
    assign fwd_mpc[t*PCW +: PCW]        = mpc_q;
    assign mispred_cnt[t*CNTW +: CNTW]  = cnt_q;
    assign status[t*3 +: 3]             = st;
    assign squashing[t]                 = (st == ROB_SQ);
    assign commit_en[t] = (st == RUNNING) || (st == IDLE) || (st == FTRAP_PEND);
  end
endmodule

module squash_resolver_chk #(
  parameter int NTHREADS = 2,
  parameter int CNTW     = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NTHREADS-1:0]      trap_sq,
  input logic [NTHREADS-1:0]      ctx_sq,
  input logic [NTHREADS-1:0]      exe_sq,
  input logic [NTHREADS-1:0]      rob_done,
  input logic [NTHREADS-1:0]      squash_valid,
  input logic [NTHREADS*2-1:0]    squash_src,
  input logic [NTHREADS-1:0]      conflict_err,
  input logic [NTHREADS-1:0]      fwd_mispred,
  input logic [NTHREADS*3-1:0]    status,
  input logic [NTHREADS*CNTW-1:0] mispred_cnt
);
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst_n;

  for (genvar t = 0; t < NTHREADS; t++) begin : g_chk
    p_trap_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_seen && $past(trap_sq[t])) |-> (squash_src[t*2 +: 2] == 2'd1));

    p_conflict_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_seen && $past(trap_sq[t] & ctx_sq[t])) |-> conflict_err[t]);

    p_enter_sq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      squash_valid[t] |-> (status[t*3 +: 3] == 3'd2));

    p_hold_sq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (status[t*3 +: 3] == 3'd2 && !rob_done[t] && !trap_sq[t] && !ctx_sq[t] && !exe_sq[t])
      |=> (status[t*3 +: 3] == 3'd2));

    p_cnt_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_seen && !(squash_valid[t] && fwd_mispred[t])) |-> $stable(mispred_cnt[t*CNTW +: CNTW]));
  end
endmodule

bind squash_resolver squash_resolver_chk #(.NTHREADS(NTHREADS), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_sq(trap_sq), .ctx_sq(ctx_sq), .exe_sq(exe_sq),
  .rob_done(rob_done), .squash_valid(squash_valid), .squash_src(squash_src),
  .conflict_err(conflict_err), .fwd_mispred(fwd_mispred), .status(status),
  .mispred_cnt(mispred_cnt));

// File: tb/squash_resolver_test.sv
module squash_resolver_test;
  localparam int N = 2, SW = 32, PW = 32, CW = 8;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] trap_sq = 0, ctx_sq = 0, exe_sq = 0, exe_mispred = 0, exe_taken = 0;
  logic [N-1:0] exe_cond_ds = 0, exe_incl = 0, rob_done = 0;
  logic [N*SW-1:0] exe_seq = 0;
  logic [N*PW-1:0] exe_npc = 0, exe_mpc = 0;
  logic [N-1:0] squash_valid, conflict_err, ds_squash, fwd_mispred, fwd_taken, squashing, commit_en;
  logic [N*2-1:0] squash_src;
  logic [N*SW-1:0] squash_bound, ds_bound;
  logic [N*PW-1:0] fwd_npc, fwd_mpc;
  logic [N*3-1:0] status;
  logic [N*CW-1:0] mispred_cnt;

  squash_resolver #(.NTHREADS(N), .SEQW(SW), .PCW(PW), .CNTW(CW)) uut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {seq, mispred, taken, cond_ds, incl, exp_bound, exp_ds, exp_dsq}
  localparam logic [100:0] VEC [8] = '{
    {32'd100, 4'b0000, 32'd100, 32'd100, 1'b1},
    {32'd100, 4'b1110, 32'd100, 32'd100, 1'b1},
    {32'd100, 4'b1100, 32'd100, 32'd101, 1'b0},
    {32'd100, 4'b1010, 32'd100, 32'd101, 1'b0},
    {32'd100, 4'b1111, 32'd99,  32'd99,  1'b1},
    {32'd100, 4'b1001, 32'd99,  32'd100, 1'b0},
    {32'd0,   4'b0001, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1},
    {32'hFFFFFFFF, 4'b1000, 32'hFFFFFFFF, 32'd0, 1'b0}
  };

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R11 reset state
    chk(status == 0, "R11 status", status, 0);
    chk(commit_en == 2'b11, "R11 commit_en", commit_en, 3);
    chk(squash_valid == 0 && conflict_err == 0 && squashing == 0, "R11 flags",
        {squash_valid, conflict_err, squashing}, 0);
    chk(mispred_cnt == 0, "R11 counter", mispred_cnt, 0);

    for (int i = 0; i < 8; i++) begin
      logic [31:0] eb, ed;
      logic [3:0] fl;
      fl = VEC[i][68:65];
      eb = VEC[i][64:33];
      ed = VEC[i][32:1];
      exe_seq[31:0] = VEC[i][100:69];
      {exe_mispred[0], exe_taken[0], exe_cond_ds[0], exe_incl[0]} = fl;
      exe_npc[31:0] = 32'h1000 + i * 16;
      exe_mpc[31:0] = 32'h2000 + i * 16;
      exe_sq[0] = 1;
      step();
      exe_sq[0] = 0;
      chk(squash_valid[0] && squash_src[1:0] == 3, "R1 exe source", squash_src[1:0], 3);
      chk(squash_bound[31:0] == eb, "R6/R7 squash bound", squash_bound[31:0], eb);
      chk(ds_bound[31:0] == ed, "R4/R5/R6/R7 ds bound", ds_bound[31:0], ed);
      chk(ds_squash[0] == VEC[i][0], "R4/R5/R6 ds squash", ds_squash[0], VEC[i][0]);
      chk(status[2:0] == 2 && squashing[0] && !commit_en[0], "R3 squashing state", status[2:0], 2);
      chk(fwd_mispred[0] == fl[3] && fwd_taken[0] == fl[2], "R9 fwd flags",
          {fwd_mispred[0], fwd_taken[0]}, fl[3:2]);
      chk(fwd_npc[31:0] == 32'h1000 + i * 16 && fwd_mpc[31:0] == 32'h2000 + i * 16, "R9 fwd pcs",
          fwd_npc[31:0], 32'h1000 + i * 16);
      step();
      chk(!squash_valid[0], "R12 pulse", squash_valid[0], 0);
      chk(squash_bound[31:0] == eb, "R12 hold", squash_bound[31:0], eb);
      chk(status[2:0] == 2 && !commit_en[0], "R8 wait drain", status[2:0], 2);
      rob_done[0] = 1;
      step();
      rob_done[0] = 0;
      chk(status[2:0] == 0 && commit_en[0], "R8 return running", status[2:0], 0);
    end
    chk(mispred_cnt[7:0] == 6, "R9 counter", mispred_cnt[7:0], 6);
    chk(status[5:3] == 0 && mispred_cnt[15:8] == 0 && squash_bound[63:32] == 0, "R10 thread1 untouched",
        status[5:3], 0);

    // R8 rob_done ignored when running
    rob_done[0] = 1; step(); rob_done[0] = 0;
    chk(status[2:0] == 0 && !squash_valid[0], "R8 drain ignored", status[2:0], 0);

    // R1 trap over exe
    trap_sq[0] = 1; exe_sq[0] = 1; exe_mispred[0] = 1; exe_seq[31:0] = 32'd500;
    step();
    trap_sq[0] = 0; exe_sq[0] = 0;
    chk(squash_src[1:0] == 1, "R1 trap wins", squash_src[1:0], 1);
    chk(!fwd_mispred[0] && squash_bound[31:0] == 32'hFFFFFFFF, "R9 trap no mispred",
        fwd_mispred[0], 0);
    chk(mispred_cnt[7:0] == 6, "R9 counter unchanged", mispred_cnt[7:0], 6);
    chk(!conflict_err[0], "R2 no conflict", conflict_err[0], 0);

    // R8 new squash in drain cycle keeps squashing
    ctx_sq[0] = 1; exe_sq[0] = 1; rob_done[0] = 1;
    step();
    ctx_sq[0] = 0; exe_sq[0] = 0; rob_done[0] = 0;
    chk(squash_src[1:0] == 2, "R1 ctx over exe", squash_src[1:0], 2);
    chk(status[2:0] == 2, "R8 squash beats drain", status[2:0], 2);

    // R2 conflict
    trap_sq[0] = 1; ctx_sq[0] = 1;
    step();
    trap_sq[0] = 0; ctx_sq[0] = 0;
    chk(conflict_err[0] && squash_src[1:0] == 1, "R2 conflict flagged", conflict_err[0], 1);
    step();
    chk(!conflict_err[0], "R2 conflict pulse", conflict_err[0], 0);

    // R10 thread 1 squash, thread 0 unaffected
    rob_done[0] = 1; step(); rob_done[0] = 0;
    exe_sq[1] = 1; exe_mispred[1] = 1; exe_seq[63:32] = 32'd7;
    step();
    exe_sq[1] = 0;
    chk(status[5:3] == 2 && squash_bound[63:32] == 7 && ds_bound[63:32] == 8, "R10 thread1 squash",
        ds_bound[63:32], 8);
    chk(status[2:0] == 0 && !squash_valid[0] && mispred_cnt[7:0] == 6, "R10 thread0 untouched",
        status[2:0], 0);
    chk(mispred_cnt[15:8] == 1, "R9 thread1 counter", mispred_cnt[15:8], 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule